// File: doc/BRIEF.md
# Channel Address Compaction Unit

This unit turns a system physical address into the address a single memory channel sees. A signed offset, counted in 64 KB pages, moves the page-level part of the address. Selected low interleave bits are then squeezed out, and the result is cut to the channel's address width. For three-way interleave, the cache-line index can also be divided by three.

A request is issued with a one-cycle `start` pulse, together with the address and the per-rule controls. Without the divide, the result appears on the next cycle. With the divide, a serial divider works one quotient bit per cycle while `busy` is high. `done` pulses once when `caddr` holds a new result, and `caddr` keeps that value until the next result arrives.

Top module: `chan_cmp_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done` and `caddr` are all zero.
- R2: The first step forms a 40-bit value. Bits [39:16] are `addr[39:16] + ofs`, taken modulo 2^24. Bits [15:6] are copied from `addr`. Bits [5:0] are zero.
- R3: Removal steps run in a fixed order: bit 8 (`sq8`) first, then bit 7 (`sq7`), then bit 6 (`sq6`). Each step acts on the output of the step before it.
- R4: Removing bit n moves every bit above n down one place, puts a zero in the top bit, and leaves bits below n unchanged. A disabled step passes its value through unchanged.
- R5: After the removal steps, only bits [36:0] are kept as the channel address.
- R6: When `by3` is set, `caddr[36:6]` is the truncated value's bits [36:6] divided by 3, rounded down, and `caddr[5:0]` keeps bits [5:0].
- R7: When `by3` is clear, an accepted `start` gives `done` high and the new `caddr` on the next cycle, and `busy` stays low.
- R8: When `by3` is set, `busy` goes high on the cycle after `start` and stays high for exactly 31 cycles. `done` pulses on the cycle `busy` drops, and `done` is never high while `busy` is high.
- R9: A `start` seen while `busy` is high is ignored. The result delivered is the one from the request already running, and no extra result follows.
- R10: `caddr` changes only on a cycle where `done` is high. In the cycle after any `done`, `caddr[5:0]` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle |
| addr | input | 40 | System physical address |
| ofs | input | 24 | Signed page offset, in 64 KB units |
| sq8 | input | 1 | Remove address bit 8 |
| sq7 | input | 1 | Remove address bit 7 |
| sq6 | input | 1 | Remove address bit 6 |
| by3 | input | 1 | Divide the line index by 3 |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle strobe: `caddr` holds a new result |
| caddr | output | 37 | Channel-local address |

## Verification
On every cycle, the assertions check the handshake timing:
- the one-cycle pass-through latency;
- the exact 31-cycle busy window, measured by a counter;
- that `busy` and `done` are never high together;
- that `caddr` holds between results and has zero line-offset bits.

Only the bench's scenarios can show the arithmetic. It checks the offset wrap, the order and effect of the removal steps, the 37-bit truncation and the quotient values, by comparing `caddr` against a behavioural model. The bench also covers the case where a request arrives during a divide and must be dropped.

// File: rtl/chan_cmp_pkg.sv
package chan_cmp_pkg;

    localparam int SYS_AW    = 40;  // system address width
    localparam int CH_AW     = 37;  // channel address width
    localparam int PAGE_LSB  = 16;  // offset granularity (64 KB)
    localparam int LINE_LSB  = 6;   // cache line offset width
    localparam int SQZ_TOP   = 8;   // first (highest) removable bit
    localparam int SQZ_N     = 3;   // number of removal stages

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DIV  = 1'b1
    } cc_state_e;

    typedef struct packed {
        logic sq8;
        logic sq7;
        logic sq6;
        logic by3;
    } cc_ctrl_t;

    // Stage k removes bit SQZ_TOP-k, so index 0 must be the bit-8 enable.
    function automatic logic [SQZ_N-1:0] squeeze_order(cc_ctrl_t c);
        return {c.sq6, c.sq7, c.sq8};
    endfunction

endpackage

// File: rtl/chan_cmp_squeeze.sv
module chan_cmp_squeeze #(
    parameter int AW   = chan_cmp_pkg::SYS_AW,
    parameter int CW   = chan_cmp_pkg::CH_AW,
    parameter int PG   = chan_cmp_pkg::PAGE_LSB,
    parameter int LN   = chan_cmp_pkg::LINE_LSB,
    parameter int TOPB = chan_cmp_pkg::SQZ_TOP,
    parameter int NRM  = chan_cmp_pkg::SQZ_N
) (
    input  logic [AW-1:0]    addr,
    input  logic [AW-PG-1:0] ofs,
    input  logic [NRM-1:0]   rm_en,
    output logic [CW-1:0]    caddr
);
    localparam int HW = AW - PG;
    localparam logic [AW-1:0] LOW_CLR = {{(AW-LN){1'b1}}, {LN{1'b0}}};

    logic [HW-1:0] hi_sum;
    logic [AW-1:0] stg [NRM+1];

    // page part moved by the signed offset, wrapping modulo 2^HW
    assign hi_sum = addr[AW-1:PG] + ofs;
    assign stg[0] = {hi_sum, addr[PG-1:0]} & LOW_CLR;

    generate
        for (genvar k = 0; k < NRM; k++) begin : g_rm
            localparam int BIT = TOPB - k;
            assign stg[k+1] = rm_en[k]
                ? {1'b0, stg[k][AW-1:BIT+1], stg[k][BIT-1:0]}
                : stg[k];
        end
    endgenerate

    assign caddr = CW'(stg[NRM]);

endmodule

// File: rtl/chan_cmp_div3.sv
module chan_cmp_div3 #(
    parameter int DW = chan_cmp_pkg::CH_AW - chan_cmp_pkg::LINE_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dvd,
    output logic          last,
    output logic [DW-1:0] quo_nxt
);
    localparam int CNT_W = (DW > 1) ? $clog2(DW) : 1;

    logic [1:0]       rem_q;
    logic [DW-1:0]    wrk_q;   // dividend shifts out at top, quotient in at bottom
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [2:0]       trial;
    logic             ge;
    logic [1:0]       rem_nxt;

    assign trial   = {rem_q, wrk_q[DW-1]};
    assign ge      = trial >= 3'd3;
    assign rem_nxt = ge ? 2'(trial - 3'd3) : trial[1:0];
    assign quo_nxt = {wrk_q[DW-2:0], ge};
    assign last    = run_q && (cnt_q == CNT_W'(DW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            wrk_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            wrk_q <= dvd;
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            rem_q <= rem_nxt;
            wrk_q <= quo_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (last) run_q <= 1'b0;
        end
    end

endmodule

// File: rtl/chan_cmp_unit.sv
module chan_cmp_unit
    import chan_cmp_pkg::*;
#(
    parameter int AW = SYS_AW,
    parameter int CW = CH_AW,
    parameter int PG = PAGE_LSB,
    parameter int LN = LINE_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    addr,
    input  logic [AW-PG-1:0] ofs,
    input  logic             sq8,
    input  logic             sq7,
    input  logic             sq6,
    input  logic             by3,
    output logic             busy,
    output logic             done,
    output logic [CW-1:0]    caddr
);
    localparam int QW = CW - LN;

    cc_ctrl_t  ctl;
    cc_state_e st_q;
    logic [CW-1:0] sq_val;
    logic [LN-1:0] low_q;
    logic [QW-1:0] quo_nxt;
    logic          accept;
    logic          go;
    logic          last;
    logic          done_q;
    logic [CW-1:0] caddr_q;

    assign ctl    = '{sq8: sq8, sq7: sq7, sq6: sq6, by3: by3};
    assign accept = start && (st_q == ST_IDLE);
    assign go     = accept && ctl.by3;

    chan_cmp_squeeze #(
        .AW(AW), .CW(CW), .PG(PG), .LN(LN), .TOPB(SQZ_TOP), .NRM(SQZ_N)
    ) i_sqz (
        .addr  (addr),
        .ofs   (ofs),
        .rm_en (squeeze_order(ctl)),
        .caddr (sq_val)
    );

    chan_cmp_div3 #(.DW(QW)) i_div (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .dvd     (sq_val[CW-1:LN]),
        .last    (last),
        .quo_nxt (quo_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b0;
            caddr_q <= '0;
            low_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (ctl.by3) begin
                    st_q  <= ST_DIV;
                    low_q <= sq_val[LN-1:0];
                end else begin
                    caddr_q <= sq_val;
                    done_q  <= 1'b1;
                end
            end else if (st_q == ST_DIV && last) begin
                caddr_q <= {quo_nxt, low_q};
                done_q  <= 1'b1;
                st_q    <= ST_IDLE;
            end
        end
    end

    assign busy  = (st_q == ST_DIV);
    assign done  = done_q;
    assign caddr = caddr_q;

endmodule

// File: rtl/chan_cmp_chk.sv
module chan_cmp_chk #(
    parameter int CW = chan_cmp_pkg::CH_AW,
    parameter int LN = chan_cmp_pkg::LINE_LSB
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          by3,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] caddr
);
    localparam int QW = CW - LN;
    localparam int LW = $clog2(QW + 2);

    logic [LW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else busy_len <= '0;
    end

    // R7
    pass_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !by3) |=> (done && !busy));

    // R8
    div_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && by3) |=> (busy && !done));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && busy_len == LW'(QW)));

    // R8
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_len <= LW'(QW));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(caddr));

    // R10
    low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (caddr[LN-1:0] == '0));

endmodule

bind chan_cmp_unit chan_cmp_chk #(.CW(CW), .LN(LN)) i_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .by3   (by3),
    .busy  (busy),
    .done  (done),
    .caddr (caddr)
);

// File: tb/test_chan_cmp_unit.sv
`timescale 1ns/1ps
module test_chan_cmp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [39:0] addr = '0;
    logic [23:0] ofs = '0;
    logic        sq8 = 1'b0, sq7 = 1'b0, sq6 = 1'b0, by3 = 1'b0;
    logic        busy, done;
    logic [36:0] caddr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    chan_cmp_unit i_chan_cmp_unit (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .ofs(ofs),
        .sq8(sq8), .sq7(sq7), .sq6(sq6), .by3(by3),
        .busy(busy), .done(done), .caddr(caddr)
    );

    function automatic logic [63:0] ref_addr(logic [39:0] a, logic [23:0] o,
                                             bit r8, bit r7, bit r6, bit d3);
        logic [63:0] x;
        logic [63:0] pg;
        pg = ((64'(a) >> 16) + 64'(o)) & 64'hFF_FFFF;
        x  = (pg << 16) | (64'(a) & 64'hFFC0);
        if (r8) x = ((x >> 1) & ~64'hFF) | (x & 64'hFF);
        if (r7) x = ((x >> 1) & ~64'h7F) | (x & 64'h7F);
        if (r6) x = ((x >> 1) & ~64'h3F) | (x & 64'h3F);
        x = x & 64'h1F_FFFF_FFFF;
        if (d3) x = (((x >> 6) / 3) << 6) | (x & 64'h3F);
        return x;
    endfunction

    // behavioural reference, advanced on every rising edge
    bit          m_live = 0;
    bit          m_busy = 0;
    bit          m_done = 0;
    logic [36:0] m_caddr = '0;
    logic [36:0] m_pend = '0;
    int          m_left = 0;

    always @(posedge clk) begin
        m_live <= 1;
        if (rst) begin
            m_busy = 0; m_done = 0; m_caddr = '0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_caddr = m_pend; m_done = 1;
                end
            end else if (start) begin
                if (by3) begin
                    m_busy = 1; m_left = 31;
                    m_pend = 37'(ref_addr(addr, ofs, sq8, sq7, sq6, 1'b1));
                end else begin
                    m_caddr = 37'(ref_addr(addr, ofs, sq8, sq7, sq6, 1'b0));
                    m_done = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            n_cmp++;
            if (busy !== m_busy || done !== m_done || caddr !== m_caddr) begin
                n_bad++;
                $display("FAIL %s cycle %0d: busy/done/caddr actual %b/%b/%h expected %b/%b/%h",
                         cur_req, cyc, busy, done, caddr, m_busy, m_done, m_caddr);
            end
        end
    end

    task automatic issue(input logic [39:0] a, input logic [23:0] o,
                         input bit r8, input bit r7, input bit r6, input bit d3,
                         input int gap);
        @(negedge clk);
        addr = a; ofs = o; sq8 = r8; sq7 = r7; sq6 = r6; by3 = d3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        repeat (3) @(negedge clk);

        cur_req = "R2";
        issue(40'h12_3456_789A, 24'h000010, 0, 0, 0, 0, 2);
        issue(40'h12_3456_789A, 24'hFFFFF0, 0, 0, 0, 0, 2);
        issue(40'hFF_FFFF_0000, 24'h000001, 0, 0, 0, 0, 2);
        issue(40'h00_0000_FFFF, 24'h000000, 0, 0, 0, 0, 2);

        cur_req = "R4";
        issue(40'h0A_5A5A_5FC0, 24'h0, 1, 0, 0, 0, 2);
        issue(40'h0A_5A5A_5FC0, 24'h0, 0, 1, 0, 0, 2);
        issue(40'h0A_5A5A_5FC0, 24'h0, 0, 0, 1, 0, 2);

        cur_req = "R3";
        issue(40'h0A_5A5A_5FC0, 24'h0, 1, 1, 1, 0, 2);
        issue(40'h00_0000_0140, 24'h0, 1, 0, 1, 0, 2);
        issue(40'h00_0000_0280, 24'h3, 1, 1, 0, 0, 2);

        cur_req = "R5";
        issue(40'hFF_FFFF_FFFF, 24'h0, 0, 0, 0, 0, 2);
        issue(40'hC0_0000_0040, 24'h0, 0, 0, 0, 0, 2);

        cur_req = "R7";
        issue(40'h01_2345_6780, 24'h7, 0, 0, 0, 0, 0);
        issue(40'h01_2345_6740, 24'h8, 1, 0, 0, 0, 0);

        cur_req = "R6";
        issue(40'h00_0000_00C0, 24'h0, 0, 0, 0, 1, 33);
        issue(40'h1F_FFFF_FFC0, 24'h0, 0, 0, 0, 1, 33);
        issue(40'h3A_BCDE_F5C0, 24'h12, 1, 0, 1, 1, 33);

        cur_req = "R8";
        issue(40'h00_1234_5640, 24'h0, 0, 1, 0, 1, 0);
        repeat (34) @(negedge clk);

        cur_req = "R9";
        issue(40'h05_5555_5540, 24'h0, 0, 0, 0, 1, 5);
        issue(40'h00_0000_0FC0, 24'h0, 0, 0, 0, 0, 40);

        cur_req = "R10";
        repeat (10) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule